// File: doc/BRIEF.md
# Memory-Map Chip-Select Decoder

This block sits beside a host processor on a 16-bit multiplexed address bus and turns each bus address into one of three active-low selects. The selects go to an external RAM, an external program ROM and an external I/O register device. The host keeps a relocatable 4K register page. The page is picked by the top address nibble and starts at page 0x1. The decoder follows that page by watching host writes to the page-mapping register, which sits at offset 0x03D of the current page. This way the external I/O device and the memories never answer in the same place.

Inside the current register page, RAM and ROM are held off, so a read there is driven only by the I/O device. The I/O select itself is narrowed to the first 256 bytes of the page. The 64 bytes at the very top of the map hold the interrupt and reset vectors. They always select the ROM, even when the register page has been moved to page 0xF.

Every select is gated by the bus data strobe E and registered once on the system clock. A select therefore reflects the address and strobe presented one clock earlier.

Top module: `memsel_decoder`

## Requirements
- R1: After synchronous reset, all three selects are inactive (high) and the register page is 0x1.
- R2: With E high, an address in 0x0000-0x7FFF that lies neither in the register page nor in the vector area drives ram_cs_n low one clock later. The other two selects stay high.
- R3: With E high, an address in 0x8000-0xFFFF outside the register page drives rom_cs_n low one clock later.
- R4: An address whose bits 15:12 equal the current page and that lies below 0xFFC0 never activates ram_cs_n or rom_cs_n.
- R5: io_cs_n goes low only for offsets 0x000-0x0FF of the current page, that is, address bits 11:8 equal to zero. It stays high for offsets 0x100-0xFFF.
- R6: Addresses 0xFFC0-0xFFFF always select the ROM, whatever the page value.
- R7: A write (bus_rw low) with E high at offset 0x03D of the current page, with bits 11:8 equal to zero, loads bus_data bits 7:4 as the new page. The decode of that same cycle still uses the old page. The new page applies from the next cycle.
- R8: A page-register write is ignored if it is an alias (offset bits 11:8 not zero), a read, or arrives with E low. The page is left unchanged.
- R9: With E low, all selects are inactive one clock later.
- R10: At most one select is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Demultiplexed bus address |
| bus_data | input | 8 | Bus data, snooped on page-register writes |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_e | input | 1 | Data strobe; selects are only active while high |
| ram_cs_n | output | 1 | Active-low external RAM select |
| rom_cs_n | output | 1 | Active-low program ROM select |
| io_cs_n | output | 1 | Active-low external I/O register device select |

## Verification
A write to the page-mapping register is itself an access inside the register page. Page tracking and address decode therefore collide in that one cycle. The bench provokes this for every page value by relocating the page with a write at offset 0x03D. It expects that cycle's selects to follow the old page and the very next access to follow the new one. Aliased, read and strobe-less writes are mixed in, and each is judged by probing the old page base afterwards. A strided sweep plus the page edges, the RAM/ROM split and the vector edges then runs for all 16 page values against a scoreboard model.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  localparam int NUM_SEL = 3;
  localparam int SEL_RAM = 0;
  localparam int SEL_ROM = 1;
  localparam int SEL_IO  = 2;

  // active-high select set, one bit per target device
  typedef logic [NUM_SEL-1:0] sel_vec_t;
endpackage

// File: rtl/memsel_page_track.sv
module memsel_page_track #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter logic [PAGE_W-1:0] RESET_PAGE = 4'h1,
  parameter logic [ADDR_W-PAGE_W-1:0] REG_OFS = 12'h03D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] data_page,
  input  logic              wr_strobe,
  output logic [PAGE_W-1:0] page
);
  localparam int OFS_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] page_q;
  logic              hit;

  // full decode of page and offset: alias writes do not match
  assign hit = wr_strobe &&
               (addr[ADDR_W-1:OFS_W] == page_q) &&
               (addr[OFS_W-1:0] == REG_OFS);

  always_ff @(posedge clk) begin
    if (rst) page_q <= RESET_PAGE;
    else if (hit) page_q <= data_page;
  end

  assign page = page_q;
endmodule

// File: rtl/memsel_region_dec.sv
module memsel_region_dec
  import memsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int IO_WIN_W = 8,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  output sel_vec_t          sel
);
  localparam int OFS_W = ADDR_W - PAGE_W;
  localparam int WIN_HI_W = OFS_W - IO_WIN_W;

  logic in_vec, in_page, in_win;

  assign in_vec  = (addr >= VEC_BASE);
  assign in_page = (addr[ADDR_W-1:OFS_W] == page);
  assign in_win  = (addr[OFS_W-1:IO_WIN_W] == {WIN_HI_W{1'b0}});

  // priority: vectors, then register page, then memory split
  always_comb begin
    sel = '0;
    if (in_vec) begin
      sel[SEL_ROM] = 1'b1;
    end else if (in_page) begin
      sel[SEL_IO] = in_win;
    end else if (addr < ROM_BASE) begin
      sel[SEL_RAM] = 1'b1;
    end else begin
      sel[SEL_ROM] = 1'b1;
    end
  end
endmodule

// File: rtl/memsel_out_stage.sv
module memsel_out_stage
  import memsel_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     strobe,
  input  sel_vec_t sel,
  output sel_vec_t sel_n
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    logic q_n;
    always_ff @(posedge clk) begin
      if (rst) q_n <= 1'b1;
      else q_n <= ~(strobe & sel[i]);
    end
    assign sel_n[i] = q_n;
  end
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
  import memsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  parameter int IO_WIN_W = 8,
  parameter logic [PAGE_W-1:0] RESET_PAGE = 4'h1,
  parameter logic [ADDR_W-PAGE_W-1:0] REG_OFS = 12'h03D,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rw,
  input  logic              bus_e,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic              io_cs_n
);
  logic [PAGE_W-1:0] io_page;
  logic              wr_strobe;
  sel_vec_t          sel_raw;
  sel_vec_t          sel_n;
  logic              unused_data_low;

  assign wr_strobe = bus_e & ~bus_rw;
  assign unused_data_low = ^bus_data[DATA_W-PAGE_W-1:0];

  memsel_page_track #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .RESET_PAGE(RESET_PAGE), .REG_OFS(REG_OFS)
  ) u_track (
    .clk(clk), .rst(rst), .addr(bus_addr),
    .data_page(bus_data[DATA_W-1 -: PAGE_W]),
    .wr_strobe(wr_strobe), .page(io_page)
  );

  memsel_region_dec #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IO_WIN_W(IO_WIN_W),
    .ROM_BASE(ROM_BASE), .VEC_BASE(VEC_BASE)
  ) u_dec (
    .addr(bus_addr), .page(io_page), .sel(sel_raw)
  );

  memsel_out_stage u_out (
    .clk(clk), .rst(rst), .strobe(bus_e), .sel(sel_raw), .sel_n(sel_n)
  );

  assign ram_cs_n = sel_n[SEL_RAM];
  assign rom_cs_n = sel_n[SEL_ROM];
  assign io_cs_n  = sel_n[SEL_IO];
endmodule

// File: rtl/memsel_decoder_chk.sv
module memsel_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  parameter logic [ADDR_W-PAGE_W-1:0] REG_OFS = 12'h03D,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_rw,
  input logic              bus_e,
  input logic              ram_cs_n,
  input logic              rom_cs_n,
  input logic              io_cs_n,
  input logic [PAGE_W-1:0] cur_page
);
  localparam int OFS_W = ADDR_W - PAGE_W;

  assert_one_select_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({~ram_cs_n, ~rom_cs_n, ~io_cs_n}) <= 1);

  assert_strobe_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_e |=> (ram_cs_n && rom_cs_n && io_cs_n));

  assert_vector_rom_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_e && bus_addr >= VEC_BASE) |=> !rom_cs_n);

  assert_page_no_mem_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_e && bus_addr[ADDR_W-1:OFS_W] == cur_page && bus_addr < VEC_BASE)
      |=> (ram_cs_n && rom_cs_n));

  assert_io_window_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_e && bus_addr[ADDR_W-1:OFS_W] == cur_page && bus_addr < VEC_BASE &&
     bus_addr[OFS_W-1:8] == '0) |=> !io_cs_n);

  assert_page_load_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_e && !bus_rw && bus_addr == {cur_page, REG_OFS})
      |=> (cur_page == $past(bus_data[DATA_W-1 -: PAGE_W])));

  assert_alias_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[ADDR_W-1:OFS_W] == cur_page && bus_addr[OFS_W-1:8] != '0)
      |=> $stable(cur_page));
endmodule

bind memsel_decoder memsel_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
  .REG_OFS(REG_OFS), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
  .bus_rw(bus_rw), .bus_e(bus_e), .ram_cs_n(ram_cs_n),
  .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n), .cur_page(io_page)
);

// File: tb/memsel_decoder_bench.sv
module memsel_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_rw = 1'b1;
  logic        bus_e = 1'b0;
  logic        ram_cs_n, rom_cs_n, io_cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0]  page_m;
  logic [2:0]  exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  memsel_decoder u_memsel_decoder (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rw(bus_rw), .bus_e(bus_e), .ram_cs_n(ram_cs_n),
    .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n)
  );

  // expected {ram_n, rom_n, io_n}, from the requirements
  function automatic logic [2:0] model(input logic [15:0] a, input logic e,
                                       input logic [3:0] pg);
    if (!e) return 3'b111;
    if (a >= 16'hFFC0) return 3'b101;
    if (a[15:12] == pg) return (a[11:8] == 4'h0) ? 3'b110 : 3'b111;
    if (a < 16'h8000) return 3'b011;
    return 3'b101;
  endfunction

  function automatic string auto_tag(input logic [15:0] a, input logic e,
                                     input logic [3:0] pg);
    if (!e) return "R9";
    if (a >= 16'hFFC0) return "R6";
    if (a[15:12] == pg) return (a[11:8] == 4'h0) ? "R5" : "R4";
    if (a < 16'h8000) return "R2";
    return "R3";
  endfunction

  task automatic drive(input logic [15:0] a, input logic [7:0] d,
                       input logic rw, input logic e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_rw = rw; bus_e = e;
    exp_q.push_back(model(a, e, page_m));
    tag_q.push_back(tag == "" ? auto_tag(a, e, page_m) : tag);
    if (e && !rw && a[15:12] == page_m && a[11:0] == 12'h03D)
      page_m = d[7:4];
  endtask

  task automatic idle();
    @(negedge clk);
    bus_e = 1'b0; bus_rw = 1'b1;
  endtask

  // monitor: compares each result one clock after its stimulus
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] exp_v, act_v;
      string t;
      exp_v = exp_q.pop_front();
      t = tag_q.pop_front();
      act_v = {ram_cs_n, rom_cs_n, io_cs_n};
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s addr=%h actual=%b expected=%b", t, bus_addr, act_v, exp_v);
      end
      checks++;
      if ($countones(~act_v) > 1) begin // R10
        errors++;
        $display("FAIL R10 actual=%b expected=at most one low", act_v);
      end
    end
  end

  task automatic set_page(input logic [3:0] p);
    drive({page_m, 12'h03D}, {p, 4'h5}, 1'b0, 1'b1, "R7");
  endtask

  initial begin
    page_m = 4'h1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset leaves selects inactive
    checks++;
    if ({ram_cs_n, rom_cs_n, io_cs_n} !== 3'b111) begin
      errors++;
      $display("FAIL R1 actual=%b expected=111", {ram_cs_n, rom_cs_n, io_cs_n});
    end
    // R1: reset page is 0x1
    drive(16'h1000, 8'h00, 1'b1, 1'b1, "R1");
    drive(16'h1100, 8'h00, 1'b1, 1'b1, "R1");
    drive(16'h0FFF, 8'h00, 1'b1, 1'b1, "R1");
    // R9: strobe low
    drive(16'h2000, 8'h00, 1'b1, 1'b0, "R9");
    drive(16'hFFFE, 8'h00, 1'b1, 1'b0, "R9");
    // R8: aliased, read, and strobe-less writes ignored
    drive(16'h143D, 8'hA0, 1'b0, 1'b1, "R8");
    drive(16'h1000, 8'h00, 1'b1, 1'b1, "R8");
    drive(16'h103D, 8'hB0, 1'b1, 1'b1, "R8");
    drive(16'h1000, 8'h00, 1'b1, 1'b1, "R8");
    drive(16'h103D, 8'hC0, 1'b0, 1'b0, "R8");
    drive(16'h1000, 8'h00, 1'b1, 1'b1, "R8");
    drive(16'hC03D, 8'hD0, 1'b0, 1'b1, "R8");
    drive(16'hC000, 8'h00, 1'b1, 1'b1, "R8");
    // R7: relocation then sweep, for every page value
    for (int p = 0; p < 16; p++) begin
      logic [3:0] pv;
      logic [15:0] base;
      pv = 4'(p);
      set_page(pv);
      base = {pv, 12'h000};
      drive(base, 8'h00, 1'b1, 1'b1, "R7");
      drive(base + 16'h03D, 8'h00, 1'b1, 1'b1, "");
      drive(base + 16'h0FF, 8'h00, 1'b1, 1'b1, "");
      drive(base + 16'h100, 8'h00, 1'b1, 1'b1, "");
      drive(base + 16'hFFF, 8'h00, 1'b1, 1'b1, "");
      drive(16'h0000, 8'h00, 1'b1, 1'b1, "");
      drive(16'h7FFF, 8'h00, 1'b1, 1'b1, "");
      drive(16'h8000, 8'h00, 1'b1, 1'b1, "");
      drive(16'hFFBF, 8'h00, 1'b1, 1'b1, "");
      drive(16'hFFC0, 8'h00, 1'b1, 1'b1, "R6");
      drive(16'hFFFF, 8'h00, 1'b1, 1'b1, "R6");
      for (int a = p * 7; a < 65536; a += 97)
        drive(16'(a), 8'h00, 1'b1, ((a / 97) % 11) != 0, "");
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule